// File: doc/BRIEF.md
# Averaging Sample Accumulator Memory

This block sums repeated acquisition frames of 12-bit samples for an averaging oscilloscope. It keeps one 32-bit running sum for each of 1000 sample positions. Each sample comes in with a one-cycle strobe and a position address. The block then reads the stored sum for that position, updates it and writes it back.

A mode input picks the update rule for each sample. In accumulate mode the zero-extended sample is added to the stored sum. In overwrite mode the sample replaces the stored sum, which starts a new frame. A separate dump input makes the block also present the freshly written sum on its output, together with a one-cycle valid pulse.

A typical acquisition runs one overwrite frame, then some number of accumulate frames. The last frame is run with dump raised, so the sums stream out in address order. Every register in the block is clocked, including the memory read port. One update takes three cycles from the strobe to the write.

Top module: `sample_accum_mem`

## Requirements
- R1: While reset is high, and in the cycle after it, the result strobe is low. The block then accepts a new sample. Reset never clears the stored sums.
- R2: With the accumulate input at 1, the stored sum becomes the previous sum plus the sample, zero-extended to 32 bits. The addition wraps modulo 2^32.
- R3: With the accumulate input at 0, the stored sum becomes the zero-extended sample alone. The previous contents are discarded.
- R4: A strobe sampled at clock edge n is written into memory at edge n+2. A further strobe is accepted again from edge n+3 onward.
- R5: When the dump input is 1 with an accepted strobe, the result strobe goes high for exactly one cycle, after edge n+2, and the output sum equals the newly written value. With dump at 0, no result strobe appears.
- R6: A strobe sampled at edge n+1 or n+2 of an update in flight is ignored. It neither changes memory nor produces output.
- R7: A strobe whose address is 1000 or above is ignored. It changes no memory, produces no output and does not make the block busy.
- R8: A reset at or before the write edge of an update in flight cancels that update. The stored sum at that address keeps its previous value.
- R9: Feed sample value a to each address a from 0 to 999. Do this first in an overwrite frame, then in nine accumulate frames, with dump on in the last frame. The dumped sums are then 10*a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smpStrobe | input | 1 | One-cycle marker of a new sample |
| smpAddr | input | 10 | Sample position, 0 to 999 |
| smpData | input | 12 | Unsigned sample value |
| modeAccum | input | 1 | 1: add to stored sum, 0: overwrite |
| modeDump | input | 1 | 1: present the new sum on the output |
| resValid | output | 1 | One-cycle marker of a presented sum |
| resSum | output | 32 | Newly written sum, valid with resValid |

## Verification
The main pattern is the full ten-frame run of samples equal to their addresses. It shows whether overwrite really discards old data and whether accumulate adds exactly once per frame: either mistake moves the final sums away from 10*a. Short streams of single strobes with dump set then test timing. Sums of 0xFFF on a preloaded value show the zero extension and the carry into the upper bits. Strobes placed one and two cycles after an accepted one tell apart a block that ignores them while busy from one that restarts. Addresses past 999, and reset pulses at each stage of an update, are followed by dumps of the addresses they could have touched.

// File: rtl/accum_pkg.sv
package accum_pkg;

  // Strobes from control to datapath for one update.
  typedef struct packed {
    logic doLatch; // capture sample, address and modes
    logic doRead;  // issue memory read of latched address
    logic doWrite; // write back and present result
  } accumCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } accumState_e;

endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       smpStrobe,
  input  logic       addrOk,
  output accumCtrl_t ctrl
);

  accumState_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (smpStrobe && addrOk) stateNext = ST_READ;
      ST_READ:  stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    ctrl.doLatch = (state == ST_IDLE) && smpStrobe && addrOk && !rst;
    ctrl.doRead  = (state == ST_READ) && !rst;
    ctrl.doWrite = (state == ST_WRITE) && !rst;
  end

  // R1: reset always leaves the control waiting
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> state == ST_IDLE);

  // R6: a read phase can only follow the waiting state
  p_read_from_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ) |-> $past(state == ST_IDLE));

  // R7: an update only starts on an in-range address
  p_range_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ) |-> $past(addrOk));

endmodule

// File: rtl/accum_dpath.sv
module accum_dpath
  import accum_pkg::*;
#(
  parameter int DEPTH    = 1000,
  parameter int SAMPLE_W = 12,
  parameter int SUM_W    = 32,
  parameter int ADDR_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  accumCtrl_t          ctrl,
  input  logic [ADDR_W-1:0]   smpAddr,
  input  logic [SAMPLE_W-1:0] smpData,
  input  logic                modeAccum,
  input  logic                modeDump,
  output logic                addrOk,
  output logic                resValid,
  output logic [SUM_W-1:0]    resSum
);

  logic [SUM_W-1:0]    sumMem [DEPTH];
  logic [ADDR_W-1:0]   addrQ;
  logic [SAMPLE_W-1:0] sampleQ;
  logic                accumQ;
  logic                dumpQ;
  logic [SUM_W-1:0]    rdData;
  logic [SUM_W-1:0]    wrData;

  generate
    if (DEPTH == (1 << ADDR_W)) begin : g_fullRange
      assign addrOk = 1'b1;
    end else begin : g_partRange
      assign addrOk = ({1'b0, smpAddr} < (ADDR_W + 1)'(DEPTH));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (ctrl.doLatch) begin
      addrQ   <= smpAddr;
      sampleQ <= smpData;
      accumQ  <= modeAccum;
      dumpQ   <= modeDump;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.doRead) rdData <= sumMem[addrQ];
  end

  always_comb begin
    if (accumQ) wrData = rdData + SUM_W'(sampleQ);
    else        wrData = SUM_W'(sampleQ);
  end

  always_ff @(posedge clk) begin
    if (ctrl.doWrite) sumMem[addrQ] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) resValid <= 1'b0;
    else     resValid <= ctrl.doWrite && dumpQ;
  end

  always_ff @(posedge clk) begin
    if (ctrl.doWrite && dumpQ) resSum <= wrData;
  end

  // R5: the result strobe lasts a single cycle
  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    resValid |=> !resValid);

  // R4: every write back is preceded by its read one cycle earlier
  p_write_after_read_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl.doWrite |-> $past(ctrl.doRead));

  // R5: a presented sum always comes from a write back
  p_valid_from_write_r5: assert property (@(posedge clk) disable iff (rst)
    resValid |-> $past(ctrl.doWrite));

endmodule

// File: rtl/sample_accum_mem.sv
module sample_accum_mem
  import accum_pkg::*;
#(
  parameter int DEPTH    = 1000,
  parameter int SAMPLE_W = 12,
  parameter int SUM_W    = 32,
  parameter int ADDR_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smpStrobe,
  input  logic [ADDR_W-1:0]   smpAddr,
  input  logic [SAMPLE_W-1:0] smpData,
  input  logic                modeAccum,
  input  logic                modeDump,
  output logic                resValid,
  output logic [SUM_W-1:0]    resSum
);

  accumCtrl_t ctrl;
  logic       addrOk;

  accum_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .smpStrobe (smpStrobe),
    .addrOk    (addrOk),
    .ctrl      (ctrl)
  );

  accum_dpath #(
    .DEPTH    (DEPTH),
    .SAMPLE_W (SAMPLE_W),
    .SUM_W    (SUM_W),
    .ADDR_W   (ADDR_W)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .smpAddr   (smpAddr),
    .smpData   (smpData),
    .modeAccum (modeAccum),
    .modeDump  (modeDump),
    .addrOk    (addrOk),
    .resValid  (resValid),
    .resSum    (resSum)
  );

endmodule

// File: tb/sim_sample_accum_mem.sv
module sim_sample_accum_mem;

  localparam int DEPTH = 1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smpStrobe = 1'b0;
  logic [9:0]  smpAddr = '0;
  logic [11:0] smpData = '0;
  logic        modeAccum = 1'b0;
  logic        modeDump = 1'b0;
  logic        resValid;
  logic [31:0] resSum;

  sample_accum_mem u0 (
    .clk(clk), .rst(rst), .smpStrobe(smpStrobe), .smpAddr(smpAddr),
    .smpData(smpData), .modeAccum(modeAccum), .modeDump(modeDump),
    .resValid(resValid), .resSum(resSum)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string curReq = "R1";
  bit tenMode = 1'b0;

  // reference model state
  logic [31:0] refMem [DEPTH];
  int          edgeNext = 0;
  int          freeAt = 0;
  bit          pendActive = 1'b0;
  int          pendEdge, pendAddr;
  bit          pendDump;
  logic [31:0] pendSum;

  task automatic step(input bit r, input bit s, input int a, input int d,
                      input bit ac, input bit dm);
    bit expValid;
    logic [31:0] expSum;
    @(negedge clk);
    expValid = 1'b0;
    expSum = '0;
    if (pendActive && pendEdge == edgeNext - 1) begin
      refMem[pendAddr] = pendSum;
      expValid = pendDump;
      expSum = tenMode ? 32'(10 * pendAddr) : pendSum;
      pendActive = 1'b0;
    end
    if (edgeNext > 0) begin
      checks++;
      if (resValid !== expValid) begin
        errors++;
        $display("FAIL %s: resValid actual %0b expected %0b (edge %0d)",
                 curReq, resValid, expValid, edgeNext - 1);
      end else if (expValid) begin
        checks++;
        if (resSum !== expSum) begin
          errors++;
          $display("FAIL %s: resSum actual %0d expected %0d", curReq, resSum, expSum);
        end
      end
    end
    if (r) begin
      if (pendActive && pendEdge >= edgeNext) pendActive = 1'b0;
      freeAt = edgeNext + 1;
    end else if (s && a < DEPTH && edgeNext >= freeAt) begin
      freeAt = edgeNext + 3;
      pendActive = 1'b1;
      pendEdge = edgeNext + 2;
      pendAddr = a;
      pendDump = dm;
      pendSum = ac ? refMem[a] + 32'(d) : 32'(d);
    end
    rst = r; smpStrobe = s; smpAddr = 10'(a); smpData = 12'(d);
    modeAccum = ac; modeDump = dm;
    edgeNext++;
  endtask

  task automatic sample4(input int a, input int d, input bit ac, input bit dm);
    step(0, 1, a, d, ac, dm);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);

    // R3: overwrite with dump, several values
    curReq = "R3";
    sample4(5, 12'hABC, 0, 1);
    sample4(6, 0, 0, 1);
    sample4(7, 12'hFFF, 0, 1);
    // R2: accumulate with zero extension and carries
    curReq = "R2";
    sample4(7, 12'hFFF, 1, 1);
    sample4(7, 12'h001, 1, 1);
    sample4(5, 12'h123, 1, 0);
    sample4(5, 0, 1, 1);
    // R5: no output without dump
    curReq = "R5";
    sample4(6, 9, 1, 0);
    sample4(6, 0, 1, 1);
    // R4: back-to-back acceptance every three cycles
    curReq = "R4";
    step(0, 1, 10, 1, 0, 1);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 1, 10, 2, 1, 1);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 1, 10, 3, 1, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0);
    // R6: strobes while busy are ignored
    curReq = "R6";
    step(0, 1, 20, 4, 0, 1);
    step(0, 1, 21, 8, 0, 1);
    step(0, 1, 22, 8, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0);
    sample4(21, 100, 0, 1);
    sample4(21, 0, 1, 1);
    sample4(20, 0, 1, 1);
    // R7: out-of-range addresses are ignored and do not block
    curReq = "R7";
    step(0, 1, 1000, 77, 0, 1);
    step(0, 1, 20, 1, 1, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0);
    sample4(1023, 5, 0, 1);
    // R8: reset in flight cancels the write
    curReq = "R8";
    step(0, 1, 20, 50, 0, 1);
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 1, 20, 60, 0, 1);
    step(0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    sample4(20, 0, 1, 1);
    // R9: ten-frame averaging run
    curReq = "R9";
    for (int f = 0; f < 10; f++) begin
      tenMode = (f == 9);
      for (int a = 0; a < DEPTH; a++) sample4(a, a, f != 0, f == 9);
    end
    step(0, 0, 0, 0, 0, 0);
    tenMode = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule